// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit with Zero and Overflow Flags

This block is a purely combinational arithmetic and logic unit for a processor datapath. Two operands of `W` bits (32 by default) and a 4-bit operation selector go in. A `W`-bit result, a zero flag and a signed-overflow flag come out in the same cycle. The unit supports addition and subtraction, each in a signed and an unsigned flavour. It also provides four bitwise operations and two less-than comparisons, one signed and one unsigned.

Addition and subtraction share a single ripple-carry chain. For subtraction, every bit of the second operand is inverted and a carry of one is injected at the least significant bit. The two comparisons reuse that same chain in subtract mode. The signed comparison takes the sign of the difference and corrects it with the overflow condition. The unsigned comparison uses the final carry as a borrow indicator.

The overflow flag is an output only: the unit contains no trap sequencing. Operand and selector are plain control-path inputs, so there is no valid/ready handshake. Back-pressure does not apply because the outputs are a pure function of the current inputs.

Top module: `int_alu`

## Requirements
- R1: With selector 0 (signed add) or 1 (unsigned add), the result equals A + B modulo 2^W.
- R2: With selector 2 (signed subtract) or 3 (unsigned subtract), the result equals A − B modulo 2^W.
- R3: The overflow flag is raised only for selectors 0 and 2, and only when the true signed result lies outside the W-bit two's complement range; selectors 1 and 3 never raise it.
- R4: For the signed add, operands whose most significant bits differ never raise the overflow flag.
- R5: Selectors 4, 5, 6 and 7 give the bitwise AND, OR, XOR and NOR of A and B respectively.
- R6: With selector 0xA, bit 0 of the result is 1 exactly when A < B as two's complement numbers, including the cases where A − B overflows.
- R7: With selector 0xB, bit 0 of the result is 1 exactly when A < B as unsigned numbers.
- R8: For selectors 0xA and 0xB, result bits W−1 down to 1 are 0.
- R9: The zero flag is 1 exactly when all W result bits are 0, for every selector value.
- R10: Selector values 8, 9 and 0xC through 0xF give a result of 0, a clear overflow flag, and therefore a set zero flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | W | First operand (A) |
| opd_b | input | W | Second operand (B) |
| op_sel | input | 4 | Operation selector |
| res | output | W | Operation result |
| zero_flag | output | 1 | High when res is all zeros |
| ovf_flag | output | 1 | Signed overflow of add or subtract (selectors 0 and 2 only) |

## Verification
The bound checker evaluates several properties whenever the inputs settle:
- addition matches A + B;
- the unsigned and non-arithmetic selectors never raise overflow;
- a signed add of operands with differing signs never overflows;
- both comparisons match native signed and unsigned less-than, with zero upper bits;
- the unused selectors give an all-zero result with the zero flag set.

Exact overflow placement at the range edges, the subtract and logic results, and zero-flag agreement across every operation are shown only by the bench. Its sweeps run a small 8-bit instance over a dense operand grid under all sixteen selectors, and a 32-bit instance over boundary operands such as the most negative value and minus one.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'h0,
    OP_ADDU = 4'h1,
    OP_SUB  = 4'h2,
    OP_SUBU = 4'h3,
    OP_AND  = 4'h4,
    OP_OR   = 4'h5,
    OP_XOR  = 4'h6,
    OP_NOR  = 4'h7,
    OP_SLT  = 4'hA,
    OP_SLTU = 4'hB
  } alu_op_e;

  // Selectors that drive the shared chain in subtract mode.
  function automatic logic op_uses_sub(logic [OP_W-1:0] op);
    return (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);
  endfunction

  // Selectors whose signed overflow is reported on the flag.
  function automatic logic op_reports_ovf(logic [OP_W-1:0] op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

endpackage

// File: rtl/alu_addsub.sv
// Shared ripple-carry chain; subtract mode inverts B and injects carry 1.
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry_out,
  output logic         s_ovf
);
  logic [W:0]   cy;
  logic [W-1:0] b_eff;

  assign cy[0] = sub;

  for (genvar g = 0; g < W; g++) begin : g_cell
    assign b_eff[g]  = b[g] ^ sub;
    assign sum[g]    = a[g] ^ b_eff[g] ^ cy[g];
    assign cy[g+1]   = (a[g] & b_eff[g]) | (a[g] & cy[g]) | (b_eff[g] & cy[g]);
  end

  assign carry_out = cy[W];
  // Carries into and out of the sign position disagree on signed overflow.
  assign s_ovf     = cy[W] ^ cy[W-1];
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   fn,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (fn)
      2'd0:    y = a & b;
      2'd1:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = ~(a | b);
    endcase
  end
endmodule

// File: rtl/alu_lessthan.sv
// Comparison from a difference computed by the shared chain.
module alu_lessthan (
  input  logic diff_msb,
  input  logic s_ovf,
  input  logic carry_out,
  input  logic is_unsigned,
  output logic lt
);
  logic lt_signed;
  logic lt_unsigned;

  // Sign of the difference is wrong exactly when the subtraction overflowed.
  assign lt_signed   = diff_msb ^ s_ovf;
  // No carry out of A + ~B + 1 means a borrow occurred.
  assign lt_unsigned = ~carry_out;
  assign lt          = is_unsigned ? lt_unsigned : lt_signed;
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]    opd_a,
  input  logic [W-1:0]    opd_b,
  input  logic [OP_W-1:0] op_sel,
  output logic [W-1:0]    res,
  output logic            zero_flag,
  output logic            ovf_flag
);
  logic [W-1:0] sum;
  logic         carry_out;
  logic         s_ovf;
  logic [W-1:0] logic_y;
  logic         lt;
  logic         sub_mode;

  assign sub_mode = op_uses_sub(op_sel);

  alu_addsub #(.W(W)) u_addsub (
    .a         (opd_a),
    .b         (opd_b),
    .sub       (sub_mode),
    .sum       (sum),
    .carry_out (carry_out),
    .s_ovf     (s_ovf)
  );

  alu_bitwise #(.W(W)) u_bitwise (
    .a  (opd_a),
    .b  (opd_b),
    .fn (op_sel[1:0]),
    .y  (logic_y)
  );

  alu_lessthan u_lessthan (
    .diff_msb    (sum[W-1]),
    .s_ovf       (s_ovf),
    .carry_out   (carry_out),
    .is_unsigned (op_sel == OP_SLTU),
    .lt          (lt)
  );

  always_comb begin
    case (op_sel)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: res = sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR:    res = logic_y;
      OP_SLT, OP_SLTU:                  res = {{(W-1){1'b0}}, lt};
      default:                          res = '0;
    endcase
  end

  assign ovf_flag  = op_reports_ovf(op_sel) & s_ovf;
  assign zero_flag = ~|res;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import int_alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic [W-1:0]    opd_a,
  input logic [W-1:0]    opd_b,
  input logic [OP_W-1:0] op_sel,
  input logic [W-1:0]    res,
  input logic            zero_flag,
  input logic            ovf_flag
);
  logic unused_op;
  assign unused_op = (op_sel == 4'h8) || (op_sel == 4'h9) || (op_sel >= 4'hC);

  always_comb begin
    if (op_sel == OP_ADD || op_sel == OP_ADDU)
      a_r1_add_sum: assert (res == opd_a + opd_b) else $error("a_r1_add_sum");
    if (op_sel != OP_ADD && op_sel != OP_SUB)
      a_r3_no_overflow: assert (!ovf_flag) else $error("a_r3_no_overflow");
    if (op_sel == OP_ADD && (opd_a[W-1] != opd_b[W-1]))
      a_r4_mixed_sign: assert (!ovf_flag) else $error("a_r4_mixed_sign");
    if (op_sel == OP_SLT)
      a_r6_signed_lt: assert (res[0] == ($signed(opd_a) < $signed(opd_b)))
        else $error("a_r6_signed_lt");
    if (op_sel == OP_SLTU)
      a_r7_unsigned_lt: assert (res[0] == (opd_a < opd_b)) else $error("a_r7_unsigned_lt");
    if (op_sel == OP_SLT || op_sel == OP_SLTU)
      a_r8_upper_zero: assert (res[W-1:1] == '0) else $error("a_r8_upper_zero");
    if (unused_op)
      a_r10_unused_op: assert (res == '0 && zero_flag && !ovf_flag) else $error("a_r10_unused_op");
  end
endmodule

bind int_alu int_alu_chk #(.W(W)) u_int_alu_chk (.*);

// File: tb/int_alu_bench.sv
module int_alu_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // Small instance for dense sweeps.
  logic [7:0]  s_a, s_b, s_res;
  logic [3:0]  s_op;
  logic        s_zero, s_ovf;
  // Full-width instance for boundary operands.
  logic [31:0] w_a, w_b, w_res;
  logic [3:0]  w_op;
  logic        w_zero, w_ovf;

  int_alu #(.W(8)) u_int_alu (
    .opd_a(s_a), .opd_b(s_b), .op_sel(s_op),
    .res(s_res), .zero_flag(s_zero), .ovf_flag(s_ovf)
  );

  int_alu #(.W(32)) u_int_alu_wide (
    .opd_a(w_a), .opd_b(w_b), .op_sel(w_op),
    .res(w_res), .zero_flag(w_zero), .ovf_flag(w_ovf)
  );

  function automatic string res_tag(logic [3:0] op);
    case (op)
      4'h0, 4'h1:             return "R1";
      4'h2, 4'h3:             return "R2";
      4'h4, 4'h5, 4'h6, 4'h7: return "R5";
      4'hA:                   return "R6/R8";
      4'hB:                   return "R7/R8";
      default:                return "R10";
    endcase
  endfunction

  // Arithmetic reference on a w-bit view of the operands.
  task automatic model(input int w, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] op, output logic [31:0] r, output logic v);
    longint mask, ua, ub, sa, sb, x, hi, lo;
    mask = (longint'(1) << w) - 1;
    ua = longint'(a) & mask;
    ub = longint'(b) & mask;
    sa = ua[w-1] ? ua - (longint'(1) << w) : ua;
    sb = ub[w-1] ? ub - (longint'(1) << w) : ub;
    hi = (longint'(1) << (w-1)) - 1;
    lo = -(longint'(1) << (w-1));
    v = 1'b0;
    case (op)
      4'h0: begin x = sa + sb; v = (x > hi) || (x < lo); end
      4'h1: x = ua + ub;
      4'h2: begin x = sa - sb; v = (x > hi) || (x < lo); end
      4'h3: x = ua - ub;
      4'h4: x = ua & ub;
      4'h5: x = ua | ub;
      4'h6: x = ua ^ ub;
      4'h7: x = ~(ua | ub);
      4'hA: x = (sa < sb) ? 1 : 0;
      4'hB: x = (ua < ub) ? 1 : 0;
      default: x = 0;
    endcase
    r = 32'(x & mask);
  endtask

  task automatic compare(input string tag, input logic [31:0] act, input logic [31:0] exp_v,
                         input logic [31:0] a, input logic [31:0] b, input logic [3:0] op);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s op=%h a=%h b=%h actual=%h expected=%h", tag, op, a, b, act, exp_v);
    end
  endtask

  task automatic run_small(input logic [7:0] a, input logic [7:0] b, input logic [3:0] op);
    logic [31:0] r;
    logic v;
    s_a = a; s_b = b; s_op = op;
    #1;
    model(8, {24'd0, a}, {24'd0, b}, op, r, v);
    compare(res_tag(op), {24'd0, s_res}, r, {24'd0, a}, {24'd0, b}, op);
    compare("R3", {31'd0, s_ovf}, {31'd0, v}, {24'd0, a}, {24'd0, b}, op);
    compare("R9", {31'd0, s_zero}, {31'd0, (r == 0)}, {24'd0, a}, {24'd0, b}, op);
    #1;
  endtask

  task automatic run_wide(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op);
    logic [31:0] r;
    logic v;
    w_a = a; w_b = b; w_op = op;
    #1;
    model(32, a, b, op, r, v);
    compare(res_tag(op), w_res, r, a, b, op);
    compare("R3", {31'd0, w_ovf}, {31'd0, v}, a, b, op);
    compare("R9", {31'd0, w_zero}, {31'd0, (r == 0)}, a, b, op);
    #1;
  endtask

  logic [31:0] edges [8];

  initial begin
    s_a = '0; s_b = '0; s_op = '0;
    w_a = '0; w_b = '0; w_op = '0;
    #1;
    // Idle inputs: R9 zero flag set, R3 overflow clear, R1 result zero.
    compare("R1", {24'd0, s_res}, 32'd0, 0, 0, 0);
    compare("R9", {31'd0, s_zero}, 32'd1, 0, 0, 0);
    compare("R3", {31'd0, w_ovf}, 32'd0, 0, 0, 0);
    #1;

    // Dense grid of the 8-bit instance under every selector.
    for (int ia = 0; ia < 86; ia++)
      for (int ib = 0; ib < 37; ib++)
        for (int op = 0; op < 16; op++)
          run_small(8'(ia * 3), 8'(ib * 7 + 3), 4'(op));

    // Sign-boundary operands on the 8-bit instance (R3, R4, R6).
    edges[0] = 32'h00; edges[1] = 32'h01; edges[2] = 32'h7F; edges[3] = 32'h80;
    edges[4] = 32'hFF; edges[5] = 32'h81; edges[6] = 32'h7E; edges[7] = 32'h40;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int op = 0; op < 16; op++)
          run_small(edges[i][7:0], edges[j][7:0], 4'(op));

    // Boundary operands on the 32-bit instance.
    edges[0] = 32'h0000_0000; edges[1] = 32'h0000_0001; edges[2] = 32'h7FFF_FFFF;
    edges[3] = 32'h8000_0000; edges[4] = 32'hFFFF_FFFF; edges[5] = 32'h8000_0001;
    edges[6] = 32'h1234_5678; edges[7] = 32'hDEAD_BEEF;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int op = 0; op < 16; op++)
          run_wide(edges[i], edges[j], 4'(op));

    // R4: max positive plus minus one on a signed add stays clear.
    run_wide(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'h0);
    // R6: min minus one overflows yet min is still less than one.
    run_wide(32'h8000_0000, 32'h0000_0001, 4'hA);
    // R7: unsigned view of all ones is not below one.
    run_wide(32'hFFFF_FFFF, 32'h0000_0001, 4'hB);
    // R10: unused selector with operands that would otherwise give nonzero.
    run_wide(32'hFFFF_FFFF, 32'h0000_0005, 4'hC);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int cycles = 0;
    while (!done && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule